// File: doc/BRIEF.md
# Sector-Timed Recirculating Loop Memory

This block models the fast storage of a bit-serial machine whose memory turns past a fixed read point. A free-running bit counter divides time into word slots of 27 bit times, and a sector counter numbers the slots 0 to 127 and then wraps. Storage is split into a 128-word main channel and four short loops of 1, 4, 8 and 16 words. In a loop of n words, the word in slot k comes round again every n slots.

A client raises `req` for one cycle with a channel, a sector and a write flag. The block waits until the addressed word turns up under the read point. It then raises `dv` for the 24 data bit times of that slot. During a read the word appears on `rdata`, least significant bit first. During a write the word is taken from `wdata` in the same order. The access time therefore depends on where the rotation stands and on how long the addressed loop is. It is not a fixed number of cycles.

Top module: `loop_mem`

## Requirements
- R1: After reset, `dv` and `rdata` are 0. The rotation starts at bit 0 of sector 0, and each clock after reset is released advances it by one bit time.
- R2: Each accepted request raises `dv` for exactly 24 consecutive cycles, with no other `dv` activity for that request.
- R3: For channel 0 (main, 128 words), `dv` rises in the first cycle of the first slot whose sector number equals `req_sec`. That slot must start at least two cycles after the cycle in which `req` was high.
- R4: Channels 1, 2, 3 and 4 are loops of 1, 4, 8 and 16 words. For a loop of n words, a slot matches when the sector number mod n equals `req_sec` mod n. The same start rule as R3 applies.
- R5: `dv` rises at most n*27+2 cycles after the request cycle, where n is the length of the addressed channel.
- R6: In a write, the bit on `wdata` in the i-th `dv` cycle (i = 0..23) becomes bit i of the stored word. In a read, bit i of the stored word appears on `rdata` in the i-th `dv` cycle.
- R7: A read does not change the stored word. Reading the same address again returns the same value.
- R8: A write changes only the word in its matched slot. Every other word of every channel keeps its value.
- R9: A `req` raised while a request is pending or being served is ignored.
- R10: `rdata` is 0 whenever `dv` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_ch | input | 3 | Channel: 0 main, 1..4 loops of 1/4/8/16 words, 5..7 alias main |
| req_sec | input | 7 | Requested sector |
| wdata | input | 1 | Serial write data, LSB first |
| rdata | output | 1 | Serial read data, LSB first |
| dv | output | 1 | High during the 24 data bits of the served slot |

## Verification
The bench keeps its own count of clock edges since reset release. From that count it works out the bit and sector position, and from those it computes the cycle in which `dv` must rise: the first slot start that is at least two cycles after the request cycle and whose sector matches for the addressed channel length. At that exact cycle it compares the measured rise and the latency bound. It then samples or drives one serial bit per cycle for 24 cycles. One cycle after the window it checks that `dv` has fallen. Stored values are checked by read sweeps over every loop word and every main sector after write sweeps and a single overwrite.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  parameter int SLOT_BITS = 27;
  parameter int DATA_BITS = 24;
  parameter int SECTORS   = 128;
  parameter int N_LOOPS   = 4;
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int BIT_W  = $clog2(SLOT_BITS);
  localparam int CH_W   = 3;
  localparam int LEN_W  = SEC_W + 1;

  // loop i (0-based) holds 1, 4, 8, 16 ... words
  function automatic int loop_len(input int i);
    return (i == 0) ? 1 : (1 << (i + 1));
  endfunction

  function automatic int total_words();
    int s = SECTORS;
    for (int i = 0; i < N_LOOPS; i++) s += loop_len(i);
    return s;
  endfunction

  localparam int TOTAL = total_words();
  localparam int IDX_W = $clog2(TOTAL);

  function automatic int ch_len(input logic [CH_W-1:0] ch);
    if (ch >= 1 && int'(ch) <= N_LOOPS) return loop_len(int'(ch) - 1);
    return SECTORS;
  endfunction

  function automatic int ch_base(input logic [CH_W-1:0] ch);
    int b = SECTORS;
    if (ch == 0 || int'(ch) > N_LOOPS) return 0;
    for (int i = 0; i < int'(ch) - 1; i++) b += loop_len(i);
    return b;
  endfunction

  // slot within the channel that a given sector position maps to
  function automatic logic [SEC_W-1:0] slot_of(input logic [CH_W-1:0] ch,
                                                input logic [SEC_W-1:0] sec);
    logic [SEC_W-1:0] mask;
    mask = SEC_W'(ch_len(ch) - 1);
    return sec & mask;
  endfunction
endpackage

// File: rtl/lpm_rotor.sv
module lpm_rotor
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [BIT_W-1:0] bit_idx,
  output logic [SEC_W-1:0] sec_now,
  output logic [SEC_W-1:0] sec_next,
  output logic             slot_last
);
  assign slot_last = (bit_idx == BIT_W'(SLOT_BITS - 1));
  assign sec_next  = sec_now + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      sec_now <= '0;
    end else if (slot_last) begin
      bit_idx <= '0;
      sec_now <= sec_next;
    end else begin
      bit_idx <= bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/lpm_sched.sv
module lpm_sched
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic [CH_W-1:0]  req_ch,
  input  logic [SEC_W-1:0] req_sec,
  input  logic             slot_last,
  input  logic [SEC_W-1:0] sec_next,
  input  logic [BIT_W-1:0] bit_idx,
  output logic             pend,
  output logic             act,
  output logic             we_q,
  output logic [CH_W-1:0]  ch_q,
  output logic [SEC_W-1:0] sec_q
);
  logic accept, hit, done;

  assign accept = req && !pend && !act;
  assign hit    = pend && slot_last &&
                  (slot_of(ch_q, sec_next) == slot_of(ch_q, sec_q));
  assign done   = act && (bit_idx == BIT_W'(DATA_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      act   <= 1'b0;
      we_q  <= 1'b0;
      ch_q  <= '0;
      sec_q <= '0;
    end else begin
      if (accept) begin
        pend  <= 1'b1;
        we_q  <= req_we;
        ch_q  <= req_ch;
        sec_q <= req_sec;
      end else if (hit) begin
        pend <= 1'b0;
        act  <= 1'b1;
      end else if (done) begin
        act <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lpm_store.sv
module lpm_store
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             wbit,
  output logic             rbit
);
  logic [DATA_BITS-1:0] mem [TOTAL];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx][bit_idx] <= wbit;
  end

  assign rbit = rd_en ? mem[idx][bit_idx] : 1'b0;
endmodule

// File: rtl/loop_mem.sv
module loop_mem
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic [2:0]       req_ch,
  input  logic [6:0]       req_sec,
  input  logic             wdata,
  output logic             rdata,
  output logic             dv
);
  logic [BIT_W-1:0] bit_idx;
  logic [SEC_W-1:0] sec_now, sec_next, sec_q;
  logic [CH_W-1:0]  ch_q;
  logic             slot_last, pend_w, act_w, we_q;
  logic [IDX_W-1:0] word_idx;
  logic [LEN_W-1:0] cur_len;

  lpm_rotor rot_i (
    .clk(clk), .rst_n(rst_n), .bit_idx(bit_idx), .sec_now(sec_now),
    .sec_next(sec_next), .slot_last(slot_last)
  );

  lpm_sched sch_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_ch(req_ch),
    .req_sec(req_sec), .slot_last(slot_last), .sec_next(sec_next),
    .bit_idx(bit_idx), .pend(pend_w), .act(act_w), .we_q(we_q),
    .ch_q(ch_q), .sec_q(sec_q)
  );

  assign word_idx = IDX_W'(ch_base(ch_q)) + IDX_W'(slot_of(ch_q, sec_q));
  assign cur_len  = LEN_W'(ch_len(ch_q));

  lpm_store sto_i (
    .clk(clk), .wr_en(act_w && we_q), .rd_en(act_w && !we_q),
    .idx(word_idx), .bit_idx(bit_idx), .wbit(wdata), .rbit(rdata)
  );

  assign dv = act_w;
endmodule

// File: rtl/lpm_chk.sv
module lpm_chk
  import lpm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             dv,
  input logic             rdata,
  input logic             pend,
  input logic             act,
  input logic [BIT_W-1:0] bit_idx,
  input logic [LEN_W-1:0] cur_len
);
  logic [7:0]  run_q;
  logic [15:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      wait_q <= '0;
    end else begin
      run_q  <= dv ? run_q + 1'b1 : '0;
      wait_q <= pend ? wait_q + 1'b1 : '0;
    end
  end

  // R2
  dv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dv) |-> run_q == 8'(DATA_BITS));
  // R2
  dv_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dv |-> run_q < 8'(DATA_BITS));
  // R10
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dv |-> !rdata);
  // R5
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> int'(wait_q) <= int'(cur_len) * SLOT_BITS + 2);
  // R3
  slot_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv) |-> bit_idx == '0);
  // R9
  single_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(act && pend));
endmodule

bind loop_mem lpm_chk chk_i (
  .clk(clk), .rst_n(rst_n), .dv(dv), .rdata(rdata), .pend(pend_w),
  .act(act_w), .bit_idx(bit_idx), .cur_len(cur_len)
);

// File: tb/loop_mem_tb.sv
`timescale 1ns/1ps
module loop_mem_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, req_we = 0, wdata = 0;
  logic [2:0] req_ch = 0;
  logic [6:0] req_sec = 0;
  logic rdata, dv;
  int tcount = 0, checks = 0, errors = 0, stray = 0;
  logic [23:0] loop_ref [5][128];

  always #2.5 clk = ~clk;

  loop_mem dut_i (.clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
    .req_ch(req_ch), .req_sec(req_sec), .wdata(wdata), .rdata(rdata), .dv(dv));

  always @(posedge clk) tcount <= rst_n ? tcount + 1 : 0;
  always @(negedge clk) if (rst_n && !dv && rdata) stray++;

  function automatic int tb_len(input int ch);
    case (ch) 1: return 1; 2: return 4; 3: return 8; 4: return 16; default: return 128; endcase
  endfunction

  function automatic int due(input int t0, input int ch, input int sec);
    int s = t0 + 2, n = tb_len(ch);
    while ((s % 27) != 0 || (((s / 27) % 128) % n) != (sec % n)) s++;
    return s;
  endfunction

  function automatic logic [23:0] pat(input int ch, input int sec, input int salt);
    return 24'((ch * 24'h1F3A5) ^ (sec * 24'h00B71) ^ (salt * 24'h5A5A5A) ^ 24'h3C0F96);
  endfunction

  task automatic check(input bit ok, input string r, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act_v, exp_v);
    end
  endtask

  // entered and left at a negedge
  task automatic access(input bit we, input int ch, input int sec,
                        input logic [23:0] wd, output logic [23:0] rd);
    int t0 = tcount;
    int s  = due(t0, ch, sec);
    int run = 0;
    req = 1; req_we = we; req_ch = 3'(ch); req_sec = 7'(sec);
    @(negedge clk); req = 0;
    while (!dv) @(negedge clk);
    // R3 main channel timing, R4 loop timing
    check(tcount == s, (ch == 0) ? "R3 rise cycle" : "R4 rise cycle", tcount, s);
    // R5 bound
    check(tcount - t0 <= tb_len(ch) * 27 + 2, "R5 latency bound", tcount - t0, tb_len(ch) * 27 + 2);
    for (int i = 0; i < 24; i++) begin
      if (dv) run++;
      rd[i] = rdata;
      wdata = we ? wd[i] : 1'b0;
      @(negedge clk);
    end
    wdata = 0;
    // R2 window length
    check(run == 24 && !dv, "R2 dv width", run, 24);
  endtask

  task automatic finish_run();
    check(stray == 0, "R10 rdata quiet", stray, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(190000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", tcount);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] rd, rd2;
    int idle;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!dv && !rdata, "R1 reset outputs", {dv, rdata}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!dv && !rdata, "R1 outputs after release", {dv, rdata}, 0);

    // R4/R6: fill every loop word
    for (int ch = 1; ch <= 4; ch++)
      for (int s = 0; s < tb_len(ch); s++) begin
        loop_ref[ch][s] = pat(ch, s, 0);
        access(1, ch, s, loop_ref[ch][s], rd);
      end
    // R3/R6: fill main channel in ascending order
    for (int s = 0; s < 128; s++) begin
      loop_ref[0][s] = pat(0, s, 1);
      access(1, 0, s, loop_ref[0][s], rd);
    end
    // R6/R8: read back everything
    for (int ch = 0; ch <= 4; ch++)
      for (int s = 0; s < tb_len(ch); s++) begin
        access(0, ch, s, 24'h0, rd);
        check(rd == loop_ref[ch][s], "R6 R8 readback", rd, loop_ref[ch][s]);
      end
    // R7: repeated reads of scattered main sectors (long rotational waits)
    for (int k = 0; k < 12; k++) begin
      access(0, 0, (k * 37 + 5) % 128, 24'h0, rd);
      access(0, 0, (k * 37 + 5) % 128, 24'h0, rd2);
      check(rd == rd2 && rd == loop_ref[0][(k * 37 + 5) % 128], "R7 non-destructive", rd2, rd);
    end
    // R4: sector fields larger than the loop length fold by modulo
    access(0, 3, 13, 24'h0, rd);
    check(rd == loop_ref[3][5], "R4 modulo slot", rd, loop_ref[3][5]);
    // R8: one overwrite, neighbours intact
    loop_ref[4][9] = 24'hA5C3F0;
    access(1, 4, 9, loop_ref[4][9], rd);
    for (int s = 0; s < 16; s++) begin
      access(0, 4, s, 24'h0, rd);
      check(rd == loop_ref[4][s], "R8 single slot write", rd, loop_ref[4][s]);
    end
    for (int s = 0; s < 4; s++) begin
      access(0, 2, s, 24'h0, rd);
      check(rd == loop_ref[2][s], "R8 other channel intact", rd, loop_ref[2][s]);
    end
    // R9: second req while pending is dropped
    req = 1; req_we = 0; req_ch = 3'd0; req_sec = 7'd77;
    @(negedge clk);
    req = 1; req_we = 1; req_ch = 3'd4; req_sec = 7'd3;
    @(negedge clk); req = 0;
    while (!dv) @(negedge clk);
    rd = '0;
    for (int i = 0; i < 24; i++) begin rd[i] = rdata; @(negedge clk); end
    check(rd == loop_ref[0][77], "R9 first request served", rd, loop_ref[0][77]);
    idle = 0;
    repeat (600) begin if (dv) idle++; @(negedge clk); end
    check(idle == 0, "R9 ignored request", idle, 0);
    access(0, 4, 3, 24'h0, rd);
    check(rd == loop_ref[4][3], "R9 no stray write", rd, loop_ref[4][3]);
    finish_run();
  end
endmodule